// File: doc/BRIEF.md
# Xon/Xoff Receive-Stream Flow Filter

This block sits between a UART receiver and its receive FIFO. It watches each received character for the software flow-control codes held in four code inputs: a pair of stop codes and a pair of go codes. The codes can be recognised either as a single character or as two consecutive characters. A stop match requests a halt of the local transmitter, and the halt takes effect only once the character being shifted out has finished. A go match lifts the halt. Recognised codes are removed from the stream, so they never reach the FIFO. Every other character is forwarded in arrival order.

Characters enter and leave on valid/ready streams. A transfer happens on a rising clock edge where both valid and ready are high. While `out_valid` is high and `out_ready` is low, the output character stays unchanged. When the block cannot place a character, it lowers `in_ready`. The control inputs and the status outputs are plain levels.

Top module: `xonoff_filter`

## Requirements
- R1: After reset, `out_valid`, `tx_halt` and `xoff_flag` are 0 and `in_ready` is 1.
- R2: With `det_en`=1 and `pair_mode`=0, an accepted character equal to `stop_a` or `go_a` is discarded. Every other character appears on the output in arrival order.
- R3: With `det_en`=1 and `pair_mode`=1, two consecutively accepted characters `stop_a` then `stop_b` form a stop match, and `go_a` then `go_b` form a go match. Both characters of a match are discarded.
- R4: In pair mode, a held first character followed by a character that does not complete its pair is released to the output first, then the new character. The new character may itself begin a new pair.
- R5: A stop match asserts `tx_halt` at the first clock edge after the match where `tx_busy` is sampled low. While `tx_busy` stays high, `tx_halt` stays 0.
- R6: A go match clears `tx_halt` and `xoff_flag` at the edge that accepts the completing character. A go code is discarded even when no halt is pending.
- R7: A stop match sets `xoff_flag` only if `irq_en` is 1. The halt takes effect regardless of `irq_en`.
- R8: With `det_en`=0, every character passes unchanged. `tx_halt` and `xoff_flag` are 0 from the next edge on, and a held first character is released to the output.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` holds steady. No character is lost or duplicated under any pattern of `out_ready`.
- R10: If a character matches both the stop code and the go code, it is treated as a stop code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received character valid |
| in_ready | output | 1 | Block can accept a character |
| in_data | input | DATA_W | Received character |
| out_valid | output | 1 | Forwarded character valid |
| out_ready | input | 1 | FIFO can take a character |
| out_data | output | DATA_W | Forwarded character |
| stop_a | input | DATA_W | Stop code, first (or only) character |
| stop_b | input | DATA_W | Stop code, second character |
| go_a | input | DATA_W | Go code, first (or only) character |
| go_b | input | DATA_W | Go code, second character |
| det_en | input | 1 | Enable code detection |
| pair_mode | input | 1 | 1: two-character codes, 0: single-character codes |
| irq_en | input | 1 | Allow stop matches to set the flag |
| tx_busy | input | 1 | Transmitter is shifting out a character |
| tx_halt | output | 1 | Transmitter must stop after its current character |
| xoff_flag | output | 1 | Status flag: stop match seen and not yet cleared |

## Verification
The hardest state to reach is a partial pair that breaks down while the output is stalled. In that state the block must release the held first character and capture the new one, and the new one may start a fresh pair. The stimulus gets there with a repeated first stop character followed by the stop second character, and with a repeated go first character. It also runs a long stretch with a periodically lowered `out_ready`, and it disables detection while a candidate is held. A scoreboard queue records only the characters that must survive, so any lost, extra or reordered character shows up as a mismatch.

// File: rtl/xonoff_pkg.sv
package xonoff_pkg;
  // code slot order inside the comparator bank
  localparam int unsigned SLOT_STOP_A = 0;
  localparam int unsigned SLOT_STOP_B = 1;
  localparam int unsigned SLOT_GO_A   = 2;
  localparam int unsigned SLOT_GO_B   = 3;
  localparam int unsigned NUM_SLOTS   = 4;

  // kind of pair a held character may still complete
  typedef struct packed {
    logic stop;
    logic go;
  } cand_t;
endpackage

// File: rtl/xf_code_match.sv
module xf_code_match #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4
) (
  input  logic [W-1:0]        chr,
  input  logic [N-1:0][W-1:0] codes,
  output logic [N-1:0]        hit
);
  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign hit[gi] = (chr == codes[gi]);
  end
endmodule

// File: rtl/xf_out_stage.sv
module xf_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xf_halt_ctrl.sv
module xf_halt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stop_ev,
  input  logic go_ev,
  input  logic irq_en,
  input  logic tx_busy,
  output logic tx_halt,
  output logic flag
);
  logic halt_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
      tx_halt  <= 1'b0;
      flag     <= 1'b0;
    end else if (!en || go_ev) begin
      halt_req <= 1'b0;
      tx_halt  <= 1'b0;
      flag     <= 1'b0;
    end else begin
      if (stop_ev)               halt_req <= 1'b1;
      if (stop_ev && irq_en)     flag     <= 1'b1;
      if (halt_req && !tx_busy)  tx_halt  <= 1'b1;
    end
  end
endmodule

// File: rtl/xonoff_filter.sv
module xonoff_filter
  import xonoff_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic [DATA_W-1:0] stop_a,
  input  logic [DATA_W-1:0] stop_b,
  input  logic [DATA_W-1:0] go_a,
  input  logic [DATA_W-1:0] go_b,
  input  logic              det_en,
  input  logic              pair_mode,
  input  logic              irq_en,
  input  logic              tx_busy,
  output logic              tx_halt,
  output logic              xoff_flag
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] codes;
  logic [NUM_SLOTS-1:0]             hit;

  assign codes[SLOT_STOP_A] = stop_a;
  assign codes[SLOT_STOP_B] = stop_b;
  assign codes[SLOT_GO_A]   = go_a;
  assign codes[SLOT_GO_B]   = go_b;

  xf_code_match #(.W(DATA_W), .N(NUM_SLOTS)) u_match (
    .chr   (in_data),
    .codes (codes),
    .hit   (hit)
  );

  // single holding stage: pair candidate, or plain character awaiting release
  logic              hold_valid, hold_valid_n;
  logic [DATA_W-1:0] hold_data, hold_data_n;
  cand_t             hold_cand, hold_cand_n;

  logic              out_free, out_load;
  logic [DATA_W-1:0] out_ld;
  logic              stop_ev, go_ev, accept, hold_rel;
  logic              first_stop, first_go;

  assign first_stop = hit[SLOT_STOP_A];
  assign first_go   = hit[SLOT_GO_A];
  assign hold_rel   = hold_valid &&
                      (!(hold_cand.stop || hold_cand.go) || !det_en || !pair_mode);
  assign in_ready   = !hold_rel && out_free;
  assign accept     = in_valid && in_ready;

  always_comb begin
    out_load     = 1'b0;
    out_ld       = in_data;
    hold_valid_n = hold_valid;
    hold_data_n  = hold_data;
    hold_cand_n  = hold_cand;
    stop_ev      = 1'b0;
    go_ev        = 1'b0;
    if (hold_rel) begin
      if (out_free) begin
        out_load     = 1'b1;
        out_ld       = hold_data;
        hold_valid_n = 1'b0;
        hold_cand_n  = '0;
      end
    end else if (accept) begin
      if (!det_en) begin
        out_load = 1'b1;
      end else if (!pair_mode) begin
        if (first_stop)    stop_ev  = 1'b1;
        else if (first_go) go_ev    = 1'b1;
        else               out_load = 1'b1;
      end else if (hold_valid) begin
        if (hold_cand.stop && hit[SLOT_STOP_B]) begin
          stop_ev      = 1'b1;
          hold_valid_n = 1'b0;
          hold_cand_n  = '0;
        end else if (hold_cand.go && hit[SLOT_GO_B]) begin
          go_ev        = 1'b1;
          hold_valid_n = 1'b0;
          hold_cand_n  = '0;
        end else begin
          out_load     = 1'b1;
          out_ld       = hold_data;
          hold_valid_n = 1'b1;
          hold_data_n  = in_data;
          hold_cand_n  = '{stop: first_stop, go: first_go};
        end
      end else if (first_stop || first_go) begin
        hold_valid_n = 1'b1;
        hold_data_n  = in_data;
        hold_cand_n  = '{stop: first_stop, go: first_go};
      end else begin
        out_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      hold_cand  <= '0;
    end else begin
      hold_valid <= hold_valid_n;
      hold_data  <= hold_data_n;
      hold_cand  <= hold_cand_n;
    end
  end

  xf_out_stage #(.W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (out_load),
    .load_data (out_ld),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .free      (out_free)
  );

  xf_halt_ctrl u_halt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (det_en),
    .stop_ev (stop_ev),
    .go_ev   (go_ev),
    .irq_en  (irq_en),
    .tx_busy (tx_busy),
    .tx_halt (tx_halt),
    .flag    (xoff_flag)
  );
endmodule

// File: rtl/xonoff_filter_chk.sv
module xonoff_filter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              det_en,
  input logic              irq_en,
  input logic              tx_busy,
  input logic              tx_halt,
  input logic              xoff_flag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_halt_waits_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(!tx_busy));

  assert_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_flag) |-> $past(irq_en));

  assert_off_no_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> (!tx_halt && !xoff_flag));

  assert_halt_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(det_en));
endmodule

bind xonoff_filter xonoff_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .det_en    (det_en),
  .irq_en    (irq_en),
  .tx_busy   (tx_busy),
  .tx_halt   (tx_halt),
  .xoff_flag (xoff_flag),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/xonoff_filter_test.sv
module xonoff_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] C_STOP_A = 8'h13, C_STOP_B = 8'h93;
  localparam logic [7:0] C_GO_A   = 8'h11, C_GO_B   = 8'h91;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [7:0] in_data = '0, out_data;
  logic [7:0] stop_a = C_STOP_A, stop_b = C_STOP_B, go_a = C_GO_A, go_b = C_GO_B;
  logic det_en = 1'b0, pair_mode = 1'b0, irq_en = 1'b1, tx_busy = 1'b0;
  logic tx_halt, xoff_flag;
  logic stall = 1'b0;
  int   cyc = 0, n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xonoff_filter #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .stop_a(stop_a), .stop_b(stop_b), .go_a(go_a),
    .go_b(go_b), .det_en(det_en), .pair_mode(pair_mode), .irq_en(irq_en),
    .tx_busy(tx_busy), .tx_halt(tx_halt), .xoff_flag(xoff_flag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: push the character if it must survive, then hand it over
  task automatic send(input logic [7:0] c, input bit keep);
    bit ok;
    if (keep) expq.push_back(c);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = c;
    forever begin
      #(CLK_PERIOD/4);
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      #(CLK_PERIOD/2);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // out_ready pattern, changed just after each edge
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    out_ready = !stall || (cyc % 3 != 0);
  end

  // monitor: compare each delivered character with the scoreboard
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2/R9: unexpected char actual %0h expected none", out_data);
      end else begin
        check("R9 stream order", out_data, expq.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cycles(3);
    check("R1 out_valid", {7'd0, out_valid}, 8'd0);
    check("R1 tx_halt",   {7'd0, tx_halt},   8'd0);
    check("R1 xoff_flag", {7'd0, xoff_flag}, 8'd0);
    check("R1 in_ready",  {7'd0, in_ready},  8'd1);
    rst_n = 1'b1;
    det_en = 1'b1;
    cycles(2);

    // R2 single-character mode
    send(8'h41, 1); send(C_STOP_A, 0);
    check("R7 flag set", {7'd0, xoff_flag}, 8'd1);
    cycles(2);
    check("R5 halt idle tx", {7'd0, tx_halt}, 8'd1);
    send(8'h42, 1); send(C_GO_A, 0);
    check("R6 halt cleared", {7'd0, tx_halt}, 8'd0);
    check("R6 flag cleared", {7'd0, xoff_flag}, 8'd0);
    send(8'h43, 1);
    send(C_GO_A, 0);                       // R6 go code dropped while not halted
    check("R6 no halt", {7'd0, tx_halt}, 8'd0);

    // R5 wait for busy transmitter
    tx_busy = 1'b1;
    send(C_STOP_A, 0);
    cycles(4);
    check("R5 halt held off", {7'd0, tx_halt}, 8'd0);
    tx_busy = 1'b0;
    cycles(2);
    check("R5 halt after idle", {7'd0, tx_halt}, 8'd1);
    send(C_GO_A, 0);

    // R7 flag disabled
    irq_en = 1'b0;
    send(C_STOP_A, 0);
    check("R7 no flag", {7'd0, xoff_flag}, 8'd0);
    cycles(2);
    check("R7 halt anyway", {7'd0, tx_halt}, 8'd1);
    send(C_GO_A, 0);
    irq_en = 1'b1;

    // R10 stop wins when both first codes are equal
    go_a = C_STOP_A;
    send(C_STOP_A, 0);
    check("R10 stop wins", {7'd0, xoff_flag}, 8'd1);
    go_a = C_GO_A;
    send(C_GO_A, 0);
    check("R10 cleared", {7'd0, xoff_flag}, 8'd0);

    // R3 pair mode
    pair_mode = 1'b1;
    send(8'h50, 1); send(C_STOP_A, 0); send(C_STOP_B, 0); send(8'h51, 1);
    check("R3 pair stop flag", {7'd0, xoff_flag}, 8'd1);
    cycles(2);
    check("R3 pair halt", {7'd0, tx_halt}, 8'd1);
    send(C_GO_A, 0); send(C_GO_B, 0);
    check("R3 pair go", {7'd0, tx_halt}, 8'd0);

    // R4 broken pairs
    send(C_STOP_A, 1); send(8'h52, 1);
    check("R4 no halt", {7'd0, xoff_flag}, 8'd0);
    send(C_STOP_A, 1); send(C_STOP_A, 0); send(C_STOP_B, 0);
    check("R4 restart pair", {7'd0, xoff_flag}, 8'd1);
    send(C_GO_A, 1); send(C_GO_A, 0); send(C_GO_B, 0);
    check("R4 restart go", {7'd0, xoff_flag}, 8'd0);
    send(C_STOP_B, 1);

    // R9 back-pressure
    stall = 1'b1;
    for (int i = 0; i < 20; i++) send(8'h60 + 8'(i), 1);
    send(C_STOP_A, 1); send(8'h7a, 1);
    stall = 1'b0;

    // R8 disabling
    pair_mode = 1'b0;
    send(C_STOP_A, 0);
    cycles(2);
    check("R8 halted first", {7'd0, tx_halt}, 8'd1);
    det_en = 1'b0;
    cycles(1);
    check("R8 halt dropped", {7'd0, tx_halt}, 8'd0);
    check("R8 flag dropped", {7'd0, xoff_flag}, 8'd0);
    send(C_STOP_A, 1); send(C_GO_A, 1);
    det_en = 1'b1; pair_mode = 1'b1;
    send(C_STOP_A, 1);                     // held, released on disable
    det_en = 1'b0;
    cycles(3);
    send(8'h7b, 1);

    for (int i = 0; i < 200 && expq.size() != 0; i++) cycles(1);
    check("R9 all delivered", 8'(expq.size()), 8'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule